// File: doc/BRIEF.md
# GPIO Pad Configuration Register Bank

This block holds one 32-bit configuration word for each of a parameterized number of general-purpose pins (128 by default) and presents them, with a small set of fixed registers, on a simple 32-bit read/write register bus. Each pin's word carries a host-ownership flag, a receive mode, an interrupt routing value, receiver and driver disable bits, the value to drive and the sampled input level. The block drives each pin's output value and output enable from that word. It brings each pin's input through a two-flop synchronizer so that software can read it back.

Software finds the pad array through a pointer register at byte offset 0x00. That register returns the byte offset of the array from the block base. Pin n's word sits at that offset plus 4*n. A read-only lock bitmap follows the pointer: one bit per pin, packed 32 pins to a word. A set lock bit makes that pin's word immune to bus writes. The bitmap and the pointer are fixed by parameters at reset.

The bus takes one access per cycle. When `bus_en` is high, `bus_we` selects a write or a read. Read data is registered: it appears one cycle after the read strobe and stays until the next read.

Top module: `gpio_pad_bank`

## Requirements
- R1: After reset every pin word reads 0x0880_0008: owned (bit 27 = 1), receive mode disabled (bits 23:22 = 2), driver disabled (bit 3 = 1), all other bits 0. `pad_oe` and `pad_out` are all zero.
- R2: A read of byte address 0x00 returns the pad array base offset (parameter, default 0x100). Writes to it are ignored.
- R3: Byte addresses 0x04, 0x08, 0x0C and 0x10 return lock words 0 to 3. Bit b of lock word k is the lock of pin 32*k+b. Writes to these words are ignored.
- R4: Pin n's word is at base + 4*n. Bits 0, 3, 4, 21:14, 23:22 and 27 are writable and read back as written. Bits 31:28, 26:24, 13:5 and 2 read as zero.
- R5: `pad_out[n]` equals bit 0 and `pad_oe[n]` equals the inverse of bit 3 of pin n's word. Both change on the clock edge that takes the write.
- R6: Bit 1 of pin n's word is read-only. It returns `pad_in[n]` delayed by two flops, so a change made before clock edge k first appears in the data of a read strobed at edge k+2. While bit 4 (receiver disable) is set, bit 1 reads 0.
- R7: A write to the word of a pin whose lock bit is set changes neither its read-back value nor `pad_out`/`pad_oe`.
- R8: Addresses outside the pointer, lock and pad words read as zero, and writes to them change nothing. Address bits 1:0 are ignored.
- R9: `bus_rdata` is loaded on the clock edge of a read strobe and holds its value through idle cycles and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_en | input | 1 | Bus access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read, qualified by bus_en |
| bus_addr | input | ADDR_W (12) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | NUM_PINS (128) | Asynchronous input levels from the pads |
| pad_out | output | NUM_PINS (128) | Value driven on each pad |
| pad_oe | output | NUM_PINS (128) | Output enable for each pad |

## Verification
The hardest case to reach from the ports is the synchronizer latency boundary. A one-flop or three-flop path gives the same read value once the input has settled, so a check on the settled value cannot tell them apart. The bench toggles a pin's input in the same cycle it starts back-to-back reads of that pin's word, and checks the read data of each of the next three strobes. A reference model compares `pad_out`, `pad_oe` and `bus_rdata` on every clock. A full sweep of writes over all pins then checks the locked pins in every lock word.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;

  typedef struct packed {
    logic       owner;
    logic [1:0] rxmode;
    logic [7:0] intsel;
    logic       rxdis;
    logic       txdis;
    logic       tx;
  } pad_cfg_t;

  localparam pad_cfg_t CFG_RESET = '{
    owner:  1'b1,
    rxmode: 2'd2,
    intsel: 8'd0,
    rxdis:  1'b0,
    txdis:  1'b1,
    tx:     1'b0
  };

  function automatic logic [31:0] cfg_to_word(input pad_cfg_t c, input logic rx);
    logic [31:0] w;
    w        = '0;
    w[27]    = c.owner;
    w[23:22] = c.rxmode;
    w[21:14] = c.intsel;
    w[4]     = c.rxdis;
    w[3]     = c.txdis;
    w[1]     = rx;
    w[0]     = c.tx;
    return w;
  endfunction

endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
  parameter int WIDTH = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_i;
      stage2_q <= stage1_q;
    end
  end

  assign sync_o = stage2_q;

endmodule

// File: rtl/gpio_pad_decode.sv
module gpio_pad_decode #(
  parameter int ADDR_W     = 12,
  parameter int NUM_PINS   = 128,
  parameter int LOCK_WORDS = 4,
  parameter int PAD_BASE   = 'h100,
  parameter int PIN_W      = 7,
  parameter int LKI_W      = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_ptr_o,
  output logic              hit_lock_o,
  output logic              hit_pad_o,
  output logic [LKI_W-1:0]  lock_idx_o,
  output logic [PIN_W-1:0]  pin_idx_o
);

  localparam int WA_W = ADDR_W - 2;

  logic [WA_W-1:0]   word_a;
  logic [WA_W-1:0]   lock_off;
  logic [ADDR_W-1:0] pad_off;
  logic [WA_W-1:0]   pad_word;
  logic              above_base;

  always_comb begin
    word_a     = addr_i[ADDR_W-1:2];
    lock_off   = word_a - WA_W'(1);
    pad_off    = addr_i - ADDR_W'(PAD_BASE);
    pad_word   = pad_off[ADDR_W-1:2];
    above_base = addr_i >= ADDR_W'(PAD_BASE);

    hit_ptr_o  = (word_a == '0);
    hit_lock_o = (word_a != '0) && (word_a <= WA_W'(LOCK_WORDS));
    hit_pad_o  = above_base && (pad_word < WA_W'(NUM_PINS));
    lock_idx_o = lock_off[LKI_W-1:0];
    pin_idx_o  = pad_word[PIN_W-1:0];
  end

  logic unused_dec;
  assign unused_dec = ^{pad_off[1:0], lock_off[WA_W-1:LKI_W]};

endmodule

// File: rtl/gpio_pad_slot.sv
module gpio_pad_slot
  import gpio_pad_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en_i,
  input  logic        lock_i,
  input  logic [31:0] wdata_i,
  output pad_cfg_t    cfg_o,
  output logic        pad_out_o,
  output logic        pad_oe_o
);

  pad_cfg_t cfg_q;
  pad_cfg_t cfg_d;
  logic     upd;

  always_comb begin
    upd          = wr_en_i && !lock_i;
    cfg_d        = cfg_q;
    cfg_d.owner  = wdata_i[27];
    cfg_d.rxmode = wdata_i[23:22];
    cfg_d.intsel = wdata_i[21:14];
    cfg_d.rxdis  = wdata_i[4];
    cfg_d.txdis  = wdata_i[3];
    cfg_d.tx     = wdata_i[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RESET;
    end else if (upd) begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg_o     = cfg_q;
  assign pad_out_o = cfg_q.tx;
  assign pad_oe_o  = !cfg_q.txdis;

  logic unused_wbits;
  assign unused_wbits = ^{wdata_i[31:28], wdata_i[26:24], wdata_i[13:5], wdata_i[2:1]};

  AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    lock_i |=> $stable(cfg_q)); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(cfg_q)); // R4

  AST_OE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !lock_i) |=> (pad_oe_o == !$past(wdata_i[3])) && (pad_out_o == $past(wdata_i[0]))); // R5

endmodule

// File: rtl/gpio_pad_bank.sv
module gpio_pad_bank
  import gpio_pad_pkg::*;
#(
  parameter int                  ADDR_W    = 12,
  parameter int                  NUM_PINS  = 128,
  parameter int                  PAD_BASE  = 'h100,
  parameter logic [NUM_PINS-1:0] LOCK_INIT = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_en,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe
);

  localparam int PINS_PER_WORD = 32;
  localparam int LOCK_WORDS    = (NUM_PINS + PINS_PER_WORD - 1) / PINS_PER_WORD;
  localparam int PIN_W         = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
  localparam int LKI_W         = (LOCK_WORDS > 1) ? $clog2(LOCK_WORDS) : 1;
  localparam logic [LOCK_WORDS*PINS_PER_WORD-1:0] LOCK_VEC =
    (LOCK_WORDS*PINS_PER_WORD)'(LOCK_INIT);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end

  assign rst_int_n = rst_pipe[1];

  // address decode
  logic             hit_ptr;
  logic             hit_lock;
  logic             hit_pad;
  logic [LKI_W-1:0] lock_idx;
  logic [PIN_W-1:0] pin_idx;

  gpio_pad_decode #(
    .ADDR_W    (ADDR_W),
    .NUM_PINS  (NUM_PINS),
    .LOCK_WORDS(LOCK_WORDS),
    .PAD_BASE  (PAD_BASE),
    .PIN_W     (PIN_W),
    .LKI_W     (LKI_W)
  ) decode_i (
    .addr_i    (bus_addr),
    .hit_ptr_o (hit_ptr),
    .hit_lock_o(hit_lock),
    .hit_pad_o (hit_pad),
    .lock_idx_o(lock_idx),
    .pin_idx_o (pin_idx)
  );

  // input synchronizer
  logic [NUM_PINS-1:0] rx_sync;

  gpio_pad_sync #(
    .WIDTH(NUM_PINS)
  ) sync_i (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .async_i(pad_in),
    .sync_o (rx_sync)
  );

  // per-pin configuration words
  logic     pad_wr;
  pad_cfg_t cfg_arr [NUM_PINS];

  assign pad_wr = bus_en && bus_we && hit_pad && !hit_ptr && !hit_lock;

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    logic wr_this;
    assign wr_this = pad_wr && (pin_idx == PIN_W'(n));

    gpio_pad_slot slot_i (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .wr_en_i  (wr_this),
      .lock_i   (LOCK_INIT[n]),
      .wdata_i  (bus_wdata),
      .cfg_o    (cfg_arr[n]),
      .pad_out_o(pad_out[n]),
      .pad_oe_o (pad_oe[n])
    );
  end

  // read path: next-state select, then register
  logic        rd_strobe;
  logic [31:0] rd_word;
  logic [31:0] rdata_q;
  pad_cfg_t    sel_cfg;
  logic        sel_rx;

  always_comb begin
    rd_strobe = bus_en && !bus_we;
    sel_cfg   = cfg_arr[pin_idx];
    sel_rx    = rx_sync[pin_idx] && !sel_cfg.rxdis;
    rd_word   = '0;
    if (hit_ptr) begin
      rd_word = 32'(PAD_BASE);
    end else if (hit_lock) begin
      rd_word = LOCK_VEC[PINS_PER_WORD*int'(lock_idx) +: PINS_PER_WORD];
    end else if (hit_pad) begin
      rd_word = cfg_to_word(sel_cfg, sel_rx);
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rdata_q <= '0;
    end else if (rd_strobe) begin
      rdata_q <= rd_word;
    end
  end

  assign bus_rdata = rdata_q;

  AST_PTR_READ: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd_strobe && hit_ptr) |=> (bus_rdata == 32'(PAD_BASE))); // R2

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd_strobe && !hit_ptr && !hit_lock && !hit_pad) |=> (bus_rdata == '0)); // R8

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    !rd_strobe |=> $stable(bus_rdata)); // R9

endmodule

// File: tb/gpio_pad_bank_tb_top.sv
`timescale 1ns/1ps
module gpio_pad_bank_tb_top;

  localparam int           NP    = 128;
  localparam logic [127:0] LOCKS = 128'h8000_0001_0000_0000_0000_0010_0000_0004; // pins 2,36,96,127
  localparam logic [31:0]  WMASK = 32'h08FF_C019;
  localparam logic [31:0]  RSTW  = 32'h0880_0008;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_en = 1'b0;
  logic          bus_we = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_drv = '0;
  logic [NP-1:0] pad_out;
  logic [NP-1:0] pad_oe;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  chk_on   = 1'b0;
  bit  done     = 1'b0;

  always #10 clk = ~clk;

  gpio_pad_bank #(
    .ADDR_W   (12),
    .NUM_PINS (NP),
    .PAD_BASE ('h100),
    .LOCK_INIT(LOCKS)
  ) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_en   (bus_en),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .pad_in   (pin_drv),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe)
  );

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [31:0]   m_cfg [NP];
  logic [NP-1:0] m_s1, m_s2;
  logic [31:0]   m_rdata;

  function automatic logic [31:0] m_read(input logic [11:0] a_in);
    int a;
    int i;
    a = int'(a_in) & ~3;
    if (a == 0) return 32'h100;
    if (a >= 4 && a <= 16) return LOCKS[(a/4-1)*32 +: 32];
    if (a >= 'h100 && a < 'h100 + 4*NP) begin
      i = (a - 'h100) / 4;
      return m_cfg[i] | {30'b0, m_s2[i] & ~m_cfg[i][4], 1'b0};
    end
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NP; i++) m_cfg[i] = RSTW;
      m_s1 = '0; m_s2 = '0; m_rdata = '0;
    end else begin
      if (bus_en && !bus_we) m_rdata = m_read(bus_addr);
      if (bus_en && bus_we) begin
        int a;
        a = int'(bus_addr) & ~3;
        if (a >= 'h100 && a < 'h100 + 4*NP && !LOCKS[(a - 'h100)/4])
          m_cfg[(a - 'h100)/4] = bus_wdata & WMASK;
      end
      m_s2 = m_s1;
      m_s1 = pin_drv;
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      logic [NP-1:0] eo, ee;
      for (int i = 0; i < NP; i++) begin
        eo[i] = m_cfg[i][0];
        ee[i] = ~m_cfg[i][3];
      end
      check("R9 model rdata", 128'(bus_rdata), 128'(m_rdata));
      check("R5 model pad_out", pad_out, eo);
      check("R5 model pad_oe", pad_oe, ee);
    end
  end

  task automatic do_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic do_read(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
    check(tag, 128'(bus_rdata), 128'(exp));
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [NP-1:0] exp_out, exp_oe;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_on = 1'b1;

    // R1 reset state
    check("R1 pad_oe after reset", pad_oe, '0);
    check("R1 pad_out after reset", pad_out, '0);
    do_read(12'h100, RSTW, "R1 pin0 reset word");
    do_read(12'h2FC, RSTW, "R1 pin127 reset word");

    // R2 pointer
    do_read(12'h000, 32'h100, "R2 pointer");
    do_write(12'h000, 32'hFFFF_FFFF);
    do_read(12'h000, 32'h100, "R2 pointer after write");

    // R3 lock words
    do_read(12'h004, 32'h0000_0004, "R3 lock word0");
    do_read(12'h008, 32'h0000_0010, "R3 lock word1");
    do_read(12'h00C, 32'h0000_0000, "R3 lock word2");
    do_read(12'h010, 32'h8000_0001, "R3 lock word3");
    do_write(12'h004, 32'hFFFF_FFFF);
    do_read(12'h004, 32'h0000_0004, "R3 lock word0 after write");

    // R4 / R5 writable fields and pad drive
    do_write(12'h114, 32'hFFFF_FFFF);
    do_read(12'h114, 32'h08FF_C019, "R4 pin5 field mask");
    check("R5 pin5 oe with driver disabled", 128'(pad_oe[5]), 128'(0));
    do_write(12'h114, 32'h0000_0001);
    check("R5 pin5 pad_out", 128'(pad_out[5]), 128'(1));
    check("R5 pin5 pad_oe", 128'(pad_oe[5]), 128'(1));
    do_read(12'h114, 32'h0000_0001, "R4 pin5 readback");

    // R7 locked pins
    do_write(12'h108, 32'h0000_0001);
    do_read(12'h108, RSTW, "R7 locked pin2 word");
    check("R7 locked pin2 pad_oe", 128'(pad_oe[2]), 128'(0));
    do_write(12'h190, 32'h0000_0001);
    do_read(12'h190, RSTW, "R7 locked pin36 word");

    // R6 synchronizer latency, back-to-back reads
    do_write(12'h124, 32'h0);
    @(negedge clk);
    pin_drv[9] = 1'b1;
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = 12'h124;
    @(negedge clk);
    check("R6 rx one edge after change", 128'(bus_rdata), 128'(0));
    @(negedge clk);
    check("R6 rx two edges after change", 128'(bus_rdata), 128'(0));
    @(negedge clk);
    bus_en = 1'b0;
    check("R6 rx visible at third strobe", 128'(bus_rdata), 128'(32'h2));
    do_write(12'h124, 32'h10);
    do_read(12'h124, 32'h10, "R6 rx gated by receiver disable");

    // R8 unmapped and low address bits
    do_read(12'h014, 32'h0, "R8 gap below pad array");
    do_write(12'h300, 32'hFFFF_FFFF);
    do_read(12'h300, 32'h0, "R8 above pad array");
    do_read(12'hFFC, 32'h0, "R8 top of space");
    do_read(12'h117, 32'h0000_0001, "R8 low address bits ignored");

    // R9 hold through idle and write
    repeat (3) @(negedge clk);
    check("R9 hold through idle", 128'(bus_rdata), 128'(32'h1));
    do_write(12'h118, 32'h0000_0001);
    check("R9 hold through write", 128'(bus_rdata), 128'(32'h1));

    // sweep every pin, odd pins drive 1
    for (int n = 0; n < NP; n++)
      do_write(12'(32'h100 + 4*n), (n % 2 == 1) ? 32'h1 : 32'h0);
    for (int n = 0; n < NP; n++) begin
      exp_out[n] = (n % 2 == 1) && !LOCKS[n];
      exp_oe[n]  = !LOCKS[n];
    end
    check("R5 R7 sweep pad_out", pad_out, exp_out);
    check("R5 R7 sweep pad_oe", pad_oe, exp_oe);
    do_read(12'h280, RSTW, "R7 locked pin96 after sweep");

    repeat (2) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule